// File: doc/BRIEF.md
# Storage-Card Slot Control and Status Registers

This block is a small set of word-addressed registers that sit beside a storage-card slot. Software reads an identification word and an address-decode word, both constant, plus a flash-programming word that is only a placeholder. It always reads zero, and writes to it are dropped.

The slot-event word carries two flags. The write-protect flag shows the level of the slot's write-protect switch, live, with no storage in between. The card-insert flag is sticky. A high insert input sets it, and it stays set after the input falls. Only software clears it, by writing a one to that bit position. The sticky flag drives the interrupt output directly. An interrupt handler therefore sees a short insert pulse even if it arrives late, and it acknowledges the event by clearing the flag.

The bus is a plain single-cycle register port. The read data is a combinational function of the address and the current state. A write takes effect at the rising clock edge when the write strobe is high. There is no back-pressure: every access completes in one cycle.

Top module: `slot_ctrl_regs`

## Requirements
- R1: Word address 0 reads the constant 0x41034003.
- R2: Word address 3 reads the constant 0x00000011.
- R3: Word address 1 reads zero. A write to word 1 or word 3 changes no read value and does not change the interrupt output.
- R4: When word address 2 is read, bit 0 equals the write-protect input in that same cycle.
- R5: The card-insert input is sampled at each rising edge. If it is high, bit 3 of word 2 reads one from the following cycle on, and it stays one after the input falls.
- R6: A write to word 2 with bit 3 of the write data set clears the insert flag at that edge. A write to word 2 with bit 3 clear has no effect, whatever the other data bits are.
- R7: The interrupt output equals the insert flag (bit 3 of word 2) in every cycle.
- R8: If the insert input is high at the same edge as a clearing write, the flag stays one.
- R9: While reset is asserted (active low, synchronous), the insert flag and the interrupt output are zero.
- R10: Word addresses 4 and above read zero, and writes to them change no state.
- R11: Bits of word 2 other than bit 0 and bit 3 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Word address of the access |
| bus_wr | input | 1 | Write strobe, takes effect at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| wp_level | input | 1 | Write-protect switch level |
| card_in | input | 1 | Card-insert event input |
| card_irq | output | 1 | Interrupt output, equal to the sticky insert flag |

## Verification
The insert input is driven with a one-cycle pulse, a held level and a level that falls while the flag is still set. Together these show whether the flag is latched or only follows the input. Clearing writes are tried with bit 3 clear and all other bits set, with bit 3 alone, and in the same cycle as a high insert input. This shows whether the clear decodes the right bit, and which of set and clear wins. The write-protect input toggles while word 2 is read, to show that bit 0 is live and not registered. Writes to the constant words and to every address above 3 are interleaved with reads of word 2, so that any write that leaks into the flag shows up.

// File: rtl/slot_regs_pkg.sv
package slot_regs_pkg;
  localparam int unsigned IDX_IDENT  = 0;
  localparam int unsigned IDX_FLASH  = 1;
  localparam int unsigned IDX_EVENT  = 2;
  localparam int unsigned IDX_DECODE = 3;
  localparam int unsigned WORD_COUNT = 4;
  localparam int unsigned BIT_WPROT  = 0;
  localparam int unsigned BIT_INSERT = 3;
endpackage

// File: rtl/slot_insert_latch.sv
module slot_insert_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lvl,
  input  logic clr_req,
  output logic latched
);
  always_ff @(posedge clk) begin
    if (!rst_n) latched <= 1'b0;
    else        latched <= set_lvl | (latched & ~clr_req);
  end

  // R5 R8
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_lvl |=> latched);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clr_req) |=> latched);
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_lvl) |=> !latched);
  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched && !set_lvl) |=> !latched);
endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
  import slot_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter logic [31:0] IDENT_VAL = 32'h4103_4003,
  parameter logic [31:0] DECOD_VAL = 32'h0000_0011
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_now,
  input  logic              ins_flag,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] event_word;

  always_comb begin
    event_word             = '0;
    event_word[BIT_WPROT]  = wp_now;
    event_word[BIT_INSERT] = ins_flag;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(IDX_IDENT))       rdata = DATA_W'(IDENT_VAL);
    else if (addr == ADDR_W'(IDX_FLASH))  rdata = '0;
    else if (addr == ADDR_W'(IDX_EVENT))  rdata = event_word;
    else if (addr == ADDR_W'(IDX_DECODE)) rdata = DATA_W'(DECOD_VAL);
  end
endmodule

// File: rtl/slot_ctrl_regs.sv
module slot_ctrl_regs
  import slot_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter logic [31:0] IDENT_VAL = 32'h4103_4003,
  parameter logic [31:0] DECOD_VAL = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wp_level,
  input  logic              card_in,
  output logic              card_irq
);
  logic ins_clr;
  logic ins_flag;
  logic unused_wdata;

  assign ins_clr      = bus_wr && (bus_addr == ADDR_W'(IDX_EVENT)) && bus_wdata[BIT_INSERT];
  assign unused_wdata = ^bus_wdata;

  slot_insert_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_lvl (card_in),
    .clr_req (ins_clr),
    .latched (ins_flag)
  );

  slot_read_mux #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDENT_VAL (IDENT_VAL),
    .DECOD_VAL (DECOD_VAL)
  ) u_rmux (
    .addr     (bus_addr),
    .wp_now   (wp_level),
    .ins_flag (ins_flag),
    .rdata    (bus_rdata)
  );

  assign card_irq = ins_flag;

  // R7
  irq_matches_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(IDX_EVENT)) |-> (card_irq == bus_rdata[BIT_INSERT]));
  // R4
  wp_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(IDX_EVENT)) |-> (bus_rdata[BIT_WPROT] == wp_level));
  // R10
  high_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(WORD_COUNT)) |-> (bus_rdata == '0));
  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != ADDR_W'(IDX_EVENT) && !card_in) |=> $stable(card_irq));
endmodule

// File: tb/sim_slot_ctrl_regs.sv
module sim_slot_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wp_level = 1'b0;
  logic        card_in = 1'b0;
  logic        card_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit model_ins = 1'b0;
  bit finished  = 1'b0;

  always #10 clk = ~clk;

  slot_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_level(wp_level),
    .card_in(card_in), .card_irq(card_irq)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a, input bit wp, input bit ins);
    case (a)
      4'd0:    return 32'h4103_4003;
      4'd1:    return 32'h0;
      4'd2:    return {28'h0, ins, 2'b00, wp};
      4'd3:    return 32'h0000_0011;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0:    return "R1";
      4'd1:    return "R3";
      4'd2:    return "R4/R5/R6/R11";
      4'd3:    return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  // One bus cycle: drive at negedge, compare mid-phase, advance the model at posedge.
  task automatic step(input logic [3:0] a, input bit wr, input logic [31:0] wd,
                      input bit wp, input bit ci);
    bit clr;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_wdata = wd; wp_level = wp; card_in = ci;
    #5;
    check(tag_of(a), bus_rdata, exp_read(a, wp, model_ins));
    check("R7", {31'h0, card_irq}, {31'h0, model_ins});
    @(posedge clk);
    clr = wr && (a == 4'd2) && wd[3];
    model_ins = ci || (model_ins && !clr);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset holds the flag low even with the insert input high
    @(negedge clk); bus_addr = 4'd2; card_in = 1'b1;
    @(posedge clk); @(negedge clk); #5;
    check("R9", bus_rdata, 32'h0);
    check("R9", {31'h0, card_irq}, 32'h0);
    card_in = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_ins = 1'b0;

    // R1 R2 R3 R11: read every word
    for (int a = 0; a < 4; a++) step(a[3:0], 0, 0, 0, 0);
    // R4: live write-protect toggle
    step(2, 0, 0, 1, 0); step(2, 0, 0, 0, 0); step(2, 0, 0, 1, 0);
    // R5: single-cycle pulse latches; flag persists after fall
    step(2, 0, 0, 0, 1); step(2, 0, 0, 0, 0); step(2, 0, 0, 1, 0);
    // R3: writes to words 1 and 3 leave everything alone
    step(1, 1, 32'hFFFF_FFFF, 0, 0); step(3, 1, 32'hFFFF_FFFF, 0, 0);
    step(1, 0, 0, 0, 0); step(3, 0, 0, 0, 0); step(2, 0, 0, 0, 0);
    // R10: writes to high words ignored, reads zero
    for (int a = 4; a < 16; a++) step(a[3:0], 1, 32'hFFFF_FFFF, 0, 0);
    for (int a = 4; a < 16; a++) step(a[3:0], 0, 0, 1, 0);
    step(2, 0, 0, 0, 0);
    // R6: write with bit 3 clear, others set, does not clear
    step(2, 1, 32'hFFFF_FFF7, 1, 0); step(2, 0, 0, 0, 0);
    // R6: clearing write with bit 3 only
    step(2, 1, 32'h0000_0008, 0, 0); step(2, 0, 0, 0, 0); step(2, 0, 0, 1, 0);
    // R5: held level, then fall
    step(2, 0, 0, 0, 1); step(2, 0, 0, 0, 1); step(2, 0, 0, 0, 1); step(2, 0, 0, 0, 0);
    // R8: clear with insert high keeps flag set
    step(2, 1, 32'h0000_0008, 0, 1); step(2, 0, 0, 0, 0);
    // clear again, flag drops
    step(2, 1, 32'hFFFF_FFFF, 1, 0); step(2, 0, 0, 0, 0);
    // R3: write to word 1 while insert rises still latches
    step(1, 1, 32'h8, 0, 1); step(2, 0, 0, 0, 0);
    step(2, 1, 32'h8, 0, 0); step(0, 0, 0, 0, 0); step(2, 0, 0, 0, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule